// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block serves a small set of read-only configuration items to a host. Each item is a byte string of known length. The items sit in two banks: a generic bank and an architecture-local bank. The host picks an item by writing a 16-bit key to a selector register. It then streams the item out through a data register, one to four bytes per access. The block keeps the selected key and a running byte offset. A multi-byte read returns the bytes in stream order, with the first byte in the most significant position. Missing bytes past the end of the item are filled with zeros on the right.

Item 0 of the generic bank is a fixed 4-byte signature. Item 1 of the generic bank is a fixed 4-byte version word. All other items are placed in a byte RAM through an initialisation port, before host access begins. The initialisation port writes the RAM bytes and, for each item, a base pointer and a length.

Host access uses one valid/ready request channel and one valid/ready response channel. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Each accepted request yields exactly one response on the following cycle. `req_ready` is high when the response register is empty, or when it is being drained in that same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response data and error flag hold still.

Top module: `cfg_item_port`

## Requirements
- R1: After reset, the selected key is 0 (the signature item) and the offset is 0. The first 4-byte data read returns the signature 32'h43464731, whose byte 0x43 comes first. After reset `rsp_valid` is low and `req_ready` is high.
- R2: A successful selector write loads the key and clears the offset to zero, whatever the key value, including a key that is already selected.
- R3: Key bits [14:0] are the entry index. When the index is N_ENTRY (8) or more, the selection is invalid, and every data read returns zero with the error flag clear.
- R4: Key bit 15 chooses the bank: 0 selects the generic bank and 1 selects the architecture-local bank. The same index in the two banks names two different items.
- R5: A data read of N bytes (1 to 4) returns the next N item bytes in the low 8*N bits of `rsp_data`. The first byte sits in the highest of those positions, and all bits above them are zero. The offset then advances by the number of real item bytes consumed.
- R6: When an item ends partway through a read, the missing low-order byte positions are zero. A read that starts at or beyond the end of the item returns zero and leaves the offset unchanged.
- R7: Port codes are: 0 = data register, 1 = selector register, 2 = combined port. The data register accepts reads and writes of 1 to 4 bytes. The selector accepts only 2-byte writes. On the combined port, a 1-byte access is a data access and a 2-byte write is a selector write. Every other access gets a response with `rsp_err`=1 and `rsp_data`=0, and it changes neither the key nor the offset.
- R8: A data-register write has no effect. It returns `rsp_err`=0 and `rsp_data`=0, and it leaves both the item contents and the offset unchanged.
- R9: Generic item 1 is 4 bytes long and stored least significant byte first. Its first byte has bit 0 set, and bit 1 equal to the HAS_DMA parameter (1 by default). The other three bytes are zero, so a 4-byte read returns 32'h03000000.
- R10: Each accepted request gives one response in the next cycle, and responses come in request order. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_data` and `rsp_err` hold, and `req_ready` is low.
- R11: Through the initialisation port, a byte write stores `init_mem_byte` at `init_mem_addr`. An entry write sets the base pointer and length of slot {bank, index}. Lengths reset to zero, so an entry that has not been loaded reads as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_mem_we | input | 1 | Item RAM byte write strobe |
| init_mem_addr | input | AW (8) | Item RAM byte address |
| init_mem_byte | input | 8 | Item RAM byte value |
| init_ent_we | input | 1 | Entry descriptor write strobe |
| init_ent_slot | input | IDX_W+1 (4) | Descriptor slot: {bank, index} |
| init_ent_base | input | AW (8) | Item base address in RAM |
| init_ent_len | input | OFF_W (9) | Item length in bytes |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_port | input | 2 | 0 data, 1 selector, 2 combined |
| req_write | input | 1 | 1 write, 0 read |
| req_bytes | input | BW (3) | Access size in bytes |
| req_wdata | input | 16 | Write data (key for a selector write) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host can take the response |
| rsp_data | output | 8*MAX_RD (32) | Packed read data |
| rsp_err | output | 1 | Access was rejected |

## Verification
The hardest case to reach is a read that crosses the end of an item. The offset must sit one to three bytes short of the end when a wide read arrives, and the stimulus has to step there first with narrow reads. The bench loads a 5-byte item and a 3-byte item. It then mixes 1-, 2- and 4-byte reads so that wide reads straddle both item ends and are followed by reads that start past the end. A second difficult case is a response stalled under back-pressure while more requests wait. The bench throttles `rsp_ready` in a repeating pattern and checks that the held response stays stable and that order is kept.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;
  typedef enum logic [1:0] {
    PORT_DATA = 2'd0,
    PORT_SEL  = 2'd1,
    PORT_COMB = 2'd2
  } port_e;

  localparam int KEY_W        = 16;
  localparam int KEY_BANK_BIT = 15;
  localparam int SIG_IDX      = 0;
  localparam int VER_IDX      = 1;
  localparam int FIXED_LEN    = 4;
endpackage

// File: rtl/cfg_item_store.sv
module cfg_item_store #(
  parameter int          N_ENTRY   = 8,
  parameter int          MEM_BYTES = 256,
  parameter int          MAX_RD    = 4,
  parameter bit          HAS_DMA   = 1'b1,
  parameter logic [31:0] SIGNATURE = 32'h4346_4731,
  localparam int AW    = $clog2(MEM_BYTES),
  localparam int IDX_W = $clog2(N_ENTRY),
  localparam int OFF_W = $clog2(MEM_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_mem_we,
  input  logic [AW-1:0]       init_mem_addr,
  input  logic [7:0]          init_mem_byte,
  input  logic                init_ent_we,
  input  logic [IDX_W:0]      init_ent_slot,
  input  logic [AW-1:0]       init_ent_base,
  input  logic [OFF_W-1:0]    init_ent_len,
  input  logic                rd_bank,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic [OFF_W-1:0]    rd_off,
  output logic [OFF_W-1:0]    item_len,
  output logic [8*MAX_RD-1:0] rd_bytes
);
  import cfg_item_pkg::*;

  localparam int          SLOTS    = 2 * N_ENTRY;
  localparam logic [7:0]  VER_BYTE = {6'd0, HAS_DMA, 1'b1};

  logic [7:0]       mem    [MEM_BYTES];
  logic [AW-1:0]    base_q [SLOTS];
  logic [OFF_W-1:0] len_q  [SLOTS];

  always_ff @(posedge clk) begin
    if (init_mem_we) mem[init_mem_addr] <= init_mem_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        len_q[s]  <= '0;
        base_q[s] <= '0;
      end
    end else if (init_ent_we) begin
      len_q[init_ent_slot]  <= init_ent_len;
      base_q[init_ent_slot] <= init_ent_base;
    end
  end

  logic [IDX_W:0] slot;
  logic           is_sig, is_ver;
  assign slot   = {rd_bank, rd_idx};
  assign is_sig = !rd_bank && (int'(rd_idx) == SIG_IDX);
  assign is_ver = !rd_bank && (int'(rd_idx) == VER_IDX);

  always_comb begin
    item_len = (is_sig || is_ver) ? OFF_W'(FIXED_LEN) : len_q[slot];
  end

  for (genvar i = 0; i < MAX_RD; i++) begin : g_lane
    logic [OFF_W+2:0] pos;
    logic [AW-1:0]    addr;
    assign pos  = {3'b000, rd_off} + (OFF_W+3)'(i);
    assign addr = base_q[slot] + pos[AW-1:0];
    always_comb begin
      rd_bytes[8*i +: 8] = 8'h00;
      if (pos < {3'b000, item_len}) begin
        if (is_sig)      rd_bytes[8*i +: 8] = SIGNATURE[8*(3 - int'(pos[1:0])) +: 8];
        else if (is_ver) rd_bytes[8*i +: 8] = (pos == '0) ? VER_BYTE : 8'h00;
        else             rd_bytes[8*i +: 8] = mem[addr];
      end
    end
  end

  p_fixed_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sig || is_ver) |-> (int'(item_len) == FIXED_LEN));
endmodule

// File: rtl/cfg_cursor.sv
module cfg_cursor #(
  parameter int OFF_W  = 9,
  parameter int MAX_RD = 4,
  localparam int BW    = $clog2(MAX_RD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [15:0]      sel_key,
  input  logic             adv_en,
  input  logic [BW-1:0]    adv_cnt,
  output logic [15:0]      cur_key,
  output logic [OFF_W-1:0] cur_off
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_key <= 16'h0000;
      cur_off <= '0;
    end else if (sel_we) begin
      cur_key <= sel_key;
      cur_off <= '0;
    end else if (adv_en) begin
      cur_off <= cur_off + OFF_W'(adv_cnt);
    end
  end

  p_sel_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (cur_off == '0) && (cur_key == $past(sel_key)));
  p_adv_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |-> (int'(adv_cnt) <= MAX_RD));
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port #(
  parameter int          N_ENTRY   = 8,
  parameter int          MEM_BYTES = 256,
  parameter int          MAX_RD    = 4,
  parameter bit          HAS_DMA   = 1'b1,
  parameter logic [31:0] SIGNATURE = 32'h4346_4731,
  localparam int AW    = $clog2(MEM_BYTES),
  localparam int IDX_W = $clog2(N_ENTRY),
  localparam int OFF_W = $clog2(MEM_BYTES + 1),
  localparam int BW    = $clog2(MAX_RD + 1),
  localparam int DW    = 8 * MAX_RD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_mem_we,
  input  logic [AW-1:0]    init_mem_addr,
  input  logic [7:0]       init_mem_byte,
  input  logic             init_ent_we,
  input  logic [IDX_W:0]   init_ent_slot,
  input  logic [AW-1:0]    init_ent_base,
  input  logic [OFF_W-1:0] init_ent_len,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_port,
  input  logic             req_write,
  input  logic [BW-1:0]    req_bytes,
  input  logic [15:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_err
);
  import cfg_item_pkg::*;

  logic             acc, ok, is_sel, is_rd, key_valid;
  logic [15:0]      cur_key;
  logic [OFF_W-1:0] cur_off, item_len;
  logic [DW-1:0]    lanes, packed_rd;
  logic [BW-1:0]    consumed;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign key_valid = int'(cur_key[KEY_BANK_BIT-1:0]) < N_ENTRY;

  always_comb begin
    ok = 1'b0; is_sel = 1'b0; is_rd = 1'b0;
    case (port_e'(req_port))
      PORT_DATA: begin
        ok    = (req_bytes != '0) && (int'(req_bytes) <= MAX_RD);
        is_rd = ok && !req_write;
      end
      PORT_SEL: begin
        ok     = req_write && (int'(req_bytes) == 2);
        is_sel = ok;
      end
      PORT_COMB: begin
        if (int'(req_bytes) == 1) begin
          ok    = 1'b1;
          is_rd = !req_write;
        end else if (int'(req_bytes) == 2 && req_write) begin
          ok     = 1'b1;
          is_sel = 1'b1;
        end
      end
      default: ok = 1'b0;
    endcase
  end

  cfg_item_store #(
    .N_ENTRY(N_ENTRY), .MEM_BYTES(MEM_BYTES), .MAX_RD(MAX_RD),
    .HAS_DMA(HAS_DMA), .SIGNATURE(SIGNATURE)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .init_mem_we(init_mem_we), .init_mem_addr(init_mem_addr), .init_mem_byte(init_mem_byte),
    .init_ent_we(init_ent_we), .init_ent_slot(init_ent_slot),
    .init_ent_base(init_ent_base), .init_ent_len(init_ent_len),
    .rd_bank(cur_key[KEY_BANK_BIT]), .rd_idx(cur_key[IDX_W-1:0]), .rd_off(cur_off),
    .item_len(item_len), .rd_bytes(lanes)
  );

  always_comb begin
    int n, remain;
    n         = int'(req_bytes);
    remain    = (key_valid && item_len > cur_off) ? int'(item_len - cur_off) : 0;
    consumed  = BW'((remain < n) ? remain : n);
    packed_rd = '0;
    for (int i = 0; i < MAX_RD; i++) begin
      if (key_valid && i < n)
        packed_rd = packed_rd | (DW'(lanes[8*i +: 8]) << (8 * (n - 1 - i)));
    end
  end

  cfg_cursor #(.OFF_W(OFF_W), .MAX_RD(MAX_RD)) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .sel_we(acc && is_sel), .sel_key(req_wdata),
    .adv_en(acc && is_rd), .adv_cnt(consumed),
    .cur_key(cur_key), .cur_off(cur_off)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= is_rd ? packed_rd : '0;
      rsp_err   <= !ok;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));
  p_reject_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ok) |=> $stable(cur_key) && $stable(cur_off));
  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));
  p_invalid_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_rd && !key_valid) |=> (rsp_data == '0));
  p_off_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_rd && key_valid && cur_off >= item_len) |=> $stable(cur_off));
endmodule

// File: tb/sim_cfg_item_port.sv
module sim_cfg_item_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_mem_we = 1'b0;
  logic [7:0]  init_mem_addr = '0;
  logic [7:0]  init_mem_byte = '0;
  logic        init_ent_we = 1'b0;
  logic [3:0]  init_ent_slot = '0;
  logic [7:0]  init_ent_base = '0;
  logic [8:0]  init_ent_len = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_port = '0;
  logic        req_write = 1'b0;
  logic [2:0]  req_bytes = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_err;

  int checks = 0, errors = 0, cycles = 0, bp_cnt = 0;
  bit bp_on = 1'b0, seen_stall = 1'b0, stall_prev = 1'b0;
  logic [31:0] hold_data;
  logic [31:0] exp_q[$];
  bit          err_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cfg_item_port u0 (.*);

  always @(posedge clk) begin
    bp_cnt  <= bp_cnt + 1;
    rsp_ready <= !bp_on || (bp_cnt % 3 == 0);
  end

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid && stall_prev) begin
      chk(rsp_data == hold_data, "R10 held response", rsp_data, hold_data);
      seen_stall = 1'b1;
    end
    stall_prev = rst_n && rsp_valid && !rsp_ready;
    hold_data  = rsp_data;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected response", rsp_data, 32'h0);
      else begin
        logic [31:0] e; bit ee; string t;
        e = exp_q.pop_front(); ee = err_q.pop_front(); t = tag_q.pop_front();
        chk(rsp_data == e, t, rsp_data, e);
        chk(rsp_err == ee, {t, " err"}, {31'd0, rsp_err}, {31'd0, ee});
      end
    end
  end

  task automatic host(input logic [1:0] p, input bit w, input int nb, input logic [15:0] wd,
                      input logic [31:0] ed, input bit ee, input string tag);
    exp_q.push_back(ed); err_q.push_back(ee); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_port = p; req_write = w; req_bytes = 3'(nb); req_wdata = wd;
    forever begin
      if (req_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic sel(input logic [15:0] k, input string tag);
    host(2'd1, 1'b1, 2, k, 32'h0, 1'b0, tag);
  endtask

  task automatic rd(input int nb, input logic [31:0] ed, input string tag);
    host(2'd0, 1'b0, nb, 16'h0, ed, 1'b0, tag);
  endtask

  task automatic put_byte(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); init_mem_we = 1'b1; init_mem_addr = a; init_mem_byte = b;
    @(negedge clk); init_mem_we = 1'b0;
  endtask

  task automatic put_ent(input logic [3:0] s, input logic [7:0] base, input int len);
    @(negedge clk); init_ent_we = 1'b1; init_ent_slot = s; init_ent_base = base; init_ent_len = 9'(len);
    @(negedge clk); init_ent_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'h0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", {31'd0, req_ready}, 32'h1);
    for (int i = 0; i < 5; i++) put_byte(8'(i), 8'(8'h11 + i));
    for (int i = 0; i < 3; i++) put_byte(8'(16 + i), 8'(8'h21 + i));
    put_ent(4'd2, 8'd0, 5);
    put_ent(4'd10, 8'd16, 3);
    put_ent(4'd3, 8'd0, 0);

    rd(4, 32'h43464731, "R1 signature after reset");
    rd(1, 32'h0, "R6 read past signature end");
    sel(16'h0000, "R2 select signature");
    rd(2, 32'h00004346, "R5 two-byte packing");
    rd(1, 32'h00000047, "R5 offset advanced");
    rd(2, 32'h00003100, "R6 partial zero pad");
    sel(16'h0001, "R9 select version");
    rd(4, 32'h03000000, "R9 version word");
    sel(16'h0002, "R4 select generic 2");
    rd(1, 32'h00000011, "R5 one byte");
    rd(4, 32'h12131415, "R5 four bytes");
    rd(1, 32'h0, "R6 past end");
    sel(16'h8002, "R4 select local 2");
    rd(4, 32'h21222300, "R4 local bank with R6 pad");
    sel(16'h0002, "R2 reselect");
    rd(1, 32'h00000011, "R2 first byte");
    sel(16'h0002, "R2 same key again");
    rd(1, 32'h00000011, "R2 offset cleared");
    sel(16'h0008, "R3 invalid key");
    rd(4, 32'h0, "R3 invalid reads zero");
    sel(16'h4002, "R3 high index bit");
    rd(2, 32'h0, "R3 invalid index field");
    sel(16'h0002, "R8 select");
    host(2'd0, 1'b1, 1, 16'h00ff, 32'h0, 1'b0, "R8 data write");
    host(2'd0, 1'b1, 4, 16'hffff, 32'h0, 1'b0, "R8 wide data write");
    rd(1, 32'h00000011, "R8 contents and offset kept");
    host(2'd2, 1'b0, 1, 16'h0, 32'h00000012, 1'b0, "R7 combined byte read");
    host(2'd2, 1'b1, 2, 16'h8002, 32'h0, 1'b0, "R7 combined select");
    host(2'd2, 1'b0, 1, 16'h0, 32'h00000021, 1'b0, "R7 combined read after select");
    host(2'd2, 1'b0, 4, 16'h0, 32'h0, 1'b1, "R7 combined wide read rejected");
    host(2'd2, 1'b0, 2, 16'h0, 32'h0, 1'b1, "R7 combined 2-byte read rejected");
    host(2'd1, 1'b0, 2, 16'h0, 32'h0, 1'b1, "R7 selector read rejected");
    host(2'd1, 1'b1, 1, 16'h0001, 32'h0, 1'b1, "R7 selector 1-byte write rejected");
    host(2'd0, 1'b0, 0, 16'h0, 32'h0, 1'b1, "R7 zero size rejected");
    host(2'd0, 1'b0, 5, 16'h0, 32'h0, 1'b1, "R7 oversize rejected");
    host(2'd3, 1'b0, 1, 16'h0, 32'h0, 1'b1, "R7 unused port rejected");
    host(2'd2, 1'b0, 1, 16'h0, 32'h00000022, 1'b0, "R7 rejects left state");
    sel(16'h0003, "R11 empty entry");
    rd(4, 32'h0, "R11 unloaded length zero");
    put_ent(4'd4, 8'd16, 2);
    sel(16'h0004, "R11 new entry");
    rd(4, 32'h21220000, "R11 descriptor load");

    bp_on = 1'b1;
    sel(16'h0002, "R10 select under stall");
    rd(2, 32'h00001112, "R10 stalled read 1");
    rd(2, 32'h00001314, "R10 stalled read 2");
    rd(2, 32'h00001500, "R10 stalled read 3");
    rd(1, 32'h0, "R10 stalled read 4");
    sel(16'h0000, "R10 select");
    rd(4, 32'h43464731, "R10 stalled signature");
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
    bp_on = 1'b0;
    chk(seen_stall, "R10 stall observed", {31'd0, seen_stall}, 32'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule